// File: doc/BRIEF.md
# Bus-Aware Stretched CPU Clock Generator

This block divides a fast reference clock into a CPU clock whose low and high phases are each counted in reference periods. With the default settings and a 96 MHz reference, the idle pattern is three periods low and three high, which gives 16 MHz. While the CPU drives its active-low address strobe, each new high phase lasts four periods instead, so the clock slows to about 13.7 MHz for bus cycles. It returns to the faster pattern once the strobe has been released. The two phases need not be equal.

The address strobe is brought into the reference domain through two flops. The length of a high phase is fixed at the moment that phase begins, so no pulse is ever cut short or changed partway. Two single-cycle strobes mark the rising and falling edges of the CPU clock. Logic that must act in step with the CPU uses them.

Top module: `cpu_clk_stretch`

## Requirements
- R1: With the strobe idle, the CPU clock stays low for LOW_LEN reference cycles and high for HIGH_IDLE reference cycles (defaults 3 and 3).
- R2: When the synchronised strobe is active on the reference edge that starts a high phase, that high phase lasts HIGH_BUS reference cycles (default 4).
- R3: When the synchronised strobe is inactive at the start of a high phase, that phase returns to HIGH_IDLE cycles.
- R4: A phase length is fixed when the phase begins. A change of the strobe during a phase has no effect on that phase, and no phase is shorter than the smallest configured length.
- R5: as_n (low = active) passes two reference flops before it is used. A level first sampled on edge k can first affect a high phase that begins on edge k+2.
- R6: While rst_n is low, the CPU clock keeps toggling with LOW_LEN low and HIGH_IDLE high, whatever as_n does.
- R7: rise_stb is high for exactly the first reference cycle in which cpu_clk is high after being low.
- R8: fall_stb is high for exactly the first reference cycle in which cpu_clk is low after being high.
- R9: Unequal settings of LOW_LEN, HIGH_IDLE and HIGH_BUS are honoured exactly, including a high phase shorter than the low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock the phases are counted in |
| rst_n | input | 1 | Active-low reset; clears the strobe synchroniser |
| as_n | input | 1 | CPU address strobe, active low, asynchronous |
| cpu_clk | output | 1 | Generated CPU clock |
| rise_stb | output | 1 | One reference cycle at each cpu_clk rising edge |
| fall_stb | output | 1 | One reference cycle at each cpu_clk falling edge |

## Verification
The bench builds two copies. One uses the default lengths 3/3/4. The other uses 4 low, 2 idle high and 6 bus high, so that a short high against a long low and a large bus stretch are both covered. A behavioural model runs beside both copies and is compared every cycle. A sweep of one-cycle strobe pulses at every offset within a clock period places the synchroniser latency directly at the phase boundary.

// File: rtl/cpu_clk_stretch.sv
module cpu_clk_stretch #(
  parameter int LOW_LEN   = 3,
  parameter int HIGH_IDLE = 3,
  parameter int HIGH_BUS  = 4
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic as_n,
  output logic cpu_clk,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int MAXL  = (LOW_LEN > HIGH_IDLE) ? ((LOW_LEN > HIGH_BUS) ? LOW_LEN : HIGH_BUS)
                                               : ((HIGH_IDLE > HIGH_BUS) ? HIGH_IDLE : HIGH_BUS);
  localparam int MINL  = (LOW_LEN < HIGH_IDLE) ? ((LOW_LEN < HIGH_BUS) ? LOW_LEN : HIGH_BUS)
                                               : ((HIGH_IDLE < HIGH_BUS) ? HIGH_IDLE : HIGH_BUS);
  localparam int CW    = $clog2(MAXL + 1);
  localparam int RW    = CW + 1;

  logic [1:0]    as_sync;
  logic [CW-1:0] cnt      = '0;
  logic [CW-1:0] hi_len_q = CW'(HIGH_IDLE);
  logic          clk_q    = 1'b0;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) as_sync <= 2'b00;
    else        as_sync <= {as_sync[0], ~as_n};

  wire           bus_act   = as_sync[1];
  wire [CW-1:0]  cur_len   = clk_q ? hi_len_q : CW'(LOW_LEN);
  wire           phase_end = (cnt == cur_len - CW'(1));

  always_ff @(posedge clk_ref) begin
    if (phase_end) begin
      cnt   <= '0;
      clk_q <= ~clk_q;
      if (!clk_q) hi_len_q <= bus_act ? CW'(HIGH_BUS) : CW'(HIGH_IDLE);
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign cpu_clk  = clk_q;
  assign rise_stb =  clk_q & (cnt == '0);
  assign fall_stb = ~clk_q & (cnt == '0);

  logic [RW-1:0] run_q = '0;
  always_ff @(posedge clk_ref)
    if (rise_stb | fall_stb) run_q <= RW'(1);
    else if (run_q != '1)    run_q <= run_q + RW'(1);

  p_low_len_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rise_stb |-> run_q == RW'(LOW_LEN));
  p_high_len_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    fall_stb |-> (run_q == RW'(HIGH_IDLE) || run_q == RW'(HIGH_BUS)));
  p_min_phase_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (rise_stb || fall_stb) |-> run_q >= RW'(MINL));
  p_len_held_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cpu_clk && !rise_stb) |-> $stable(hi_len_q));
  p_rise_edge_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rise_stb |-> !$past(cpu_clk));
  p_fall_edge_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    fall_stb |-> $past(cpu_clk));
endmodule

// File: tb/tb_cpu_clk_stretch.sv
module tb_cpu_clk_stretch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1;
  always #2 clk = ~clk;

  logic cpu [2];
  logic rise [2];
  logic fall [2];

  cpu_clk_stretch dut (.clk_ref(clk), .rst_n(rst_n), .as_n(as_n),
    .cpu_clk(cpu[0]), .rise_stb(rise[0]), .fall_stb(fall[0]));
  cpu_clk_stretch #(.LOW_LEN(4), .HIGH_IDLE(2), .HIGH_BUS(6)) dut_b (.clk_ref(clk), .rst_n(rst_n), .as_n(as_n),
    .cpu_clk(cpu[1]), .rise_stb(rise[1]), .fall_stb(fall[1]));

  int lo_p [2] = '{3, 4};
  int id_p [2] = '{3, 2};
  int bu_p [2] = '{4, 6};
  int min_p[2] = '{3, 2};

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit m_clk[2] = '{0, 0};
  bit m_prev[2] = '{1, 1};
  int m_age[2] = '{0, 0};
  int m_hi[2];
  bit hist[$] = '{0, 0};
  initial begin m_hi[0] = id_p[0]; m_hi[1] = id_p[1]; end

  always @(posedge clk) begin
    bit bus;
    bus = rst_n ? hist[0] : 1'b0;
    for (int i = 0; i < 2; i++) begin
      int len;
      m_prev[i] = m_clk[i];
      len = m_clk[i] ? m_hi[i] : lo_p[i];
      m_age[i]++;
      if (m_age[i] == len) begin
        m_age[i] = 0;
        if (!m_clk[i]) m_hi[i] = bus ? bu_p[i] : id_p[i];
        m_clk[i] = !m_clk[i];
      end
    end
    void'(hist.pop_front());
    hist.push_back(rst_n ? !as_n : 1'b0);
    if (!rst_n) hist = '{0, 0};
  end

  // measured phase lengths from the outputs
  bit obs[2] = '{0, 0};
  int run[2] = '{0, 0};
  int hi_meas[2] = '{0, 0};
  int lo_meas[2] = '{0, 0};
  int min_meas[2] = '{99, 99};
  bit meas_on = 0;

  always @(negedge clk) if (!done) begin
    for (int i = 0; i < 2; i++) begin
      chk(cpu[i] == m_clk[i], tag, cpu[i], m_clk[i]);
      chk(rise[i] == (m_clk[i] && !m_prev[i]), "R7", rise[i], m_clk[i] && !m_prev[i]);
      chk(fall[i] == (!m_clk[i] && m_prev[i]), "R8", fall[i], !m_clk[i] && m_prev[i]);
      if (cpu[i] != obs[i]) begin
        if (obs[i]) hi_meas[i] = run[i]; else lo_meas[i] = run[i];
        if (meas_on && run[i] < min_meas[i]) min_meas[i] = run[i];
        run[i] = 1;
        obs[i] = cpu[i];
      end else run[i]++;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
  end

  initial begin
    bit [15:0] lfsr;
    tag = "R6";
    wait_cyc(3);
    as_n = 1'b0;
    wait_cyc(30);
    chk(hi_meas[0] == 3, "R6", hi_meas[0], 3);
    chk(lo_meas[0] == 3, "R6", lo_meas[0], 3);
    as_n = 1'b1;
    rst_n = 1'b1;
    meas_on = 1;
    tag = "R1";
    wait_cyc(30);
    chk(hi_meas[0] == 3, "R1", hi_meas[0], 3);
    chk(lo_meas[0] == 3, "R1", lo_meas[0], 3);
    chk(hi_meas[1] == 2, "R9", hi_meas[1], 2);
    chk(lo_meas[1] == 4, "R9", lo_meas[1], 4);
    tag = "R2";
    as_n = 1'b0;
    wait_cyc(40);
    chk(hi_meas[0] == 4, "R2", hi_meas[0], 4);
    chk(lo_meas[0] == 3, "R2", lo_meas[0], 3);
    chk(hi_meas[1] == 6, "R9", hi_meas[1], 6);
    tag = "R3";
    as_n = 1'b1;
    wait_cyc(30);
    chk(hi_meas[0] == 3, "R3", hi_meas[0], 3);
    chk(hi_meas[1] == 2, "R3", hi_meas[1], 2);
    tag = "R5";
    for (int off = 0; off < 14; off++) begin
      wait_cyc(off);
      as_n = 1'b0;
      wait_cyc(1);
      as_n = 1'b1;
      wait_cyc(15);
    end
    tag = "R4";
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      as_n = lfsr[0] | lfsr[3];
      wait_cyc(1);
    end
    tag = "R6";
    rst_n = 1'b0;
    as_n = 1'b0;
    meas_on = 0;
    wait_cyc(40);
    chk(hi_meas[0] == 3, "R6", hi_meas[0], 3);
    chk(hi_meas[1] == 2, "R6", hi_meas[1], 2);
    rst_n = 1'b1;
    as_n = 1'b1;
    wait_cyc(20);
    chk(min_meas[0] >= min_p[0], "R4", min_meas[0], min_p[0]);
    chk(min_meas[1] >= min_p[1], "R4", min_meas[1], min_p[1]);
    summary();
  end
endmodule